// File: doc/BRIEF.md
# Register Rename Map and Free List

This block translates architectural register names into physical register names for an out-of-order core. It holds two map tables: a speculative one, read and written at decode, and a committed one, written at retirement. It also holds a pool of unassigned physical registers. With the defaults, 32 logical registers map onto 64 physical registers, which leaves 32 spare names. Those spares bound how many renamed instructions can be in flight at once.

Decode presents two source names and one destination name. In the same cycle, without a register in between, the block returns the physical tags of both sources, a fresh tag for the destination and the tag the destination held until now. The fresh tag is taken when the request is accepted (`ren_valid` and `ren_ready` both high).

Retirement presents the logical destination, its new tag and the tag it displaces. The committed map moves to the new tag and the displaced tag goes back into the pool. No register value is copied. A recovery pulse throws away all speculative state. The speculative map is reloaded from the committed map, and the pool is refilled with every physical register the committed map does not reference, in ascending order.

Top module: `rnm_rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i in both the speculative map and the committed map.
- R2: After reset, the pool holds physical registers 32 to 63, and these are handed out in ascending order, starting with 32.
- R3: `ren_phys_a`, `ren_phys_b` and `ren_phys_prev` show the speculative mapping of `ren_src_a`, `ren_src_b` and `ren_dst`. `ren_phys_dst` shows the oldest tag in the pool. An accepted request moves the speculative entry of `ren_dst` to that tag and removes the tag from the pool.
- R4: A source that names the same register as its own instruction's destination gets the mapping from before that instruction's update.
- R5: `ren_ready` is low while the pool is empty. A request made while `ren_ready` is low changes neither the map nor the pool.
- R6: A commit sets the committed entry of `cmt_dst` to `cmt_phys_new` and appends `cmt_phys_old` at the tail of the pool. The caller must pass as `cmt_phys_old` the tag the committed map currently holds for `cmt_dst`.
- R7: One allocation and one release may happen in the same cycle, and both take effect. A release into an empty pool makes that tag available from the next cycle.
- R8: While `recover` is high, `ren_ready` is low and any commit in that cycle is ignored. On the next cycle the speculative map equals the committed map, and the pool holds 32 tags: the lowest-numbered physical registers that the committed map does not reference, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | 5 | First source logical register |
| ren_src_b | input | 5 | Second source logical register |
| ren_dst | input | 5 | Destination logical register |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_phys_a | output | 6 | Physical tag of first source |
| ren_phys_b | output | 6 | Physical tag of second source |
| ren_phys_dst | output | 6 | Fresh physical tag for the destination |
| ren_phys_prev | output | 6 | Previous speculative mapping of the destination |
| cmt_valid | input | 1 | Retirement of one instruction |
| cmt_dst | input | 5 | Logical destination of the retiring instruction |
| cmt_phys_new | input | 6 | Physical tag the retiring instruction wrote |
| cmt_phys_old | input | 6 | Physical tag displaced by it |
| recover | input | 1 | Restore speculative state from the committed state |

## Verification
A corrupt speculative map entry shows up on a source or previous-tag output as soon as decode names that register, and that lookup is combinational. A corrupt pool shows up either as a wrong `ren_phys_dst` on the next accepted request or as `ren_ready` dropping at the wrong time. A corrupt committed map stays invisible at the ports until the next recovery. After that recovery the speculative lookups and the order of the refilled pool expose it within one cycle. For this reason the bench recovers often and compares every lookup and every allocated tag against its own model.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
   localparam int unsigned LOG_REGS_DEF  = 32;
   localparam int unsigned PHYS_REGS_DEF = 64;

   // width of an index into n entries, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
   parameter int unsigned NUM_LOG  = 32,
   parameter int unsigned NUM_PHYS = 64,
   parameter int unsigned LW       = 5,
   parameter int unsigned PW       = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LW-1:0]       rd_a_log,
   input  logic [LW-1:0]       rd_b_log,
   input  logic [LW-1:0]       rd_d_log,
   output logic [PW-1:0]       rd_a_phys,
   output logic [PW-1:0]       rd_b_phys,
   output logic [PW-1:0]       rd_d_phys,
   input  logic                spec_we,
   input  logic [LW-1:0]       spec_log,
   input  logic [PW-1:0]       spec_phys,
   input  logic                cmt_we,
   input  logic [LW-1:0]       cmt_log,
   input  logic [PW-1:0]       cmt_phys,
   output logic [PW-1:0]       cmt_cur_phys,
   input  logic                recover,
   output logic [NUM_PHYS-1:0] cmt_used
);
   logic [NUM_LOG-1:0][PW-1:0] spec_q;
   logic [NUM_LOG-1:0][PW-1:0] cmt_q;

   // sources read the table before this cycle's destination write
   assign rd_a_phys    = spec_q[rd_a_log];
   assign rd_b_phys    = spec_q[rd_b_log];
   assign rd_d_phys    = spec_q[rd_d_log];
   assign cmt_cur_phys = cmt_q[cmt_log];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LOG; i++) begin
            spec_q[i] <= PW'(i);
            cmt_q[i]  <= PW'(i);
         end
      end else if (recover) begin
         spec_q <= cmt_q;
      end else begin
         if (spec_we) spec_q[spec_log] <= spec_phys;
         if (cmt_we)  cmt_q[cmt_log]   <= cmt_phys;
      end
   end

   // physical registers referenced by the committed map
   always_comb begin
      cmt_used = '0;
      for (int i = 0; i < NUM_LOG; i++) begin
         cmt_used[cmt_q[i]] = 1'b1;
      end
   end

   AST_SPEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      spec_we && !recover |=> spec_q[$past(spec_log)] == $past(spec_phys)); // R3
   AST_CMT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_we && !recover |=> cmt_q[$past(cmt_log)] == $past(cmt_phys)); // R6
   AST_RECOVER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> spec_q == $past(cmt_q)); // R8
   AST_RECOVER_CMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> $stable(cmt_q)); // R8
endmodule

// File: rtl/rnm_free_fifo.sv
module rnm_free_fifo #(
   parameter int unsigned NUM_PHYS = 64,
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned PW       = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pop,
   output logic [PW-1:0]       head_phys,
   output logic                empty,
   input  logic                push,
   input  logic [PW-1:0]       push_phys,
   input  logic                rebuild,
   input  logic [NUM_PHYS-1:0] used
);
   localparam int unsigned PTR_W  = $clog2(DEPTH);
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
   localparam int unsigned RANK_W = $clog2(NUM_PHYS + 1);
   localparam bit          POW2   = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);
   localparam logic [RANK_W-1:0] DEPTH_R = RANK_W'(DEPTH);
   localparam logic [PTR_W-1:0]  LAST_P  = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rnm_free_fifo: DEPTH must be at least 2");
   end

   logic [PW-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0]  head_q, tail_q, head_nxt, tail_nxt;
   logic [CNT_W-1:0]  count_q;
   logic [RANK_W-1:0] rank [NUM_PHYS];
   logic [RANK_W-1:0] free_total;

   if (POW2) begin : g_wrap_pow2
      assign head_nxt = head_q + 1'b1;
      assign tail_nxt = tail_q + 1'b1;
   end else begin : g_wrap_cmp
      assign head_nxt = (head_q == LAST_P) ? '0 : head_q + 1'b1;
      assign tail_nxt = (tail_q == LAST_P) ? '0 : tail_q + 1'b1;
   end

   // rank of each unreferenced register among all unreferenced ones
   always_comb begin : rank_calc
      logic [RANK_W-1:0] acc;
      acc = '0;
      for (int p = 0; p < NUM_PHYS; p++) begin
         rank[p] = acc;
         if (!used[p]) acc = acc + 1'b1;
      end
      free_total = acc;
   end

   assign head_phys = mem_q[head_q];
   assign empty     = (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            mem_q[k] <= PW'(NUM_PHYS - DEPTH + k);
         end
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= DEPTH_C;
      end else if (rebuild) begin
         for (int p = 0; p < NUM_PHYS; p++) begin
            if (!used[p] && rank[p] < DEPTH_R) mem_q[rank[p][PTR_W-1:0]] <= PW'(p);
         end
         head_q <= '0;
         if (free_total >= DEPTH_R) begin
            tail_q  <= '0;
            count_q <= DEPTH_C;
         end else begin
            tail_q  <= free_total[PTR_W-1:0];
            count_q <= free_total[CNT_W-1:0];
         end
      end else begin
         if (push) begin
            mem_q[tail_q] <= push_phys;
            tail_q        <= tail_nxt;
         end
         if (pop) head_q <= head_nxt;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop && !rebuild |-> count_q != DEPTH_C); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !rebuild |-> !empty); // R5
   AST_PAIR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !rebuild |=> $stable(count_q)); // R7
   AST_REBUILD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rebuild |=> count_q == DEPTH_C); // R8
endmodule

// File: rtl/rnm_rename_unit.sv
module rnm_rename_unit
   import rnm_pkg::*;
#(
   parameter int unsigned NUM_LOG  = LOG_REGS_DEF,
   parameter int unsigned NUM_PHYS = PHYS_REGS_DEF,
   localparam int unsigned LW      = idx_w(NUM_LOG),
   localparam int unsigned PW      = idx_w(NUM_PHYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ren_valid,
   input  logic [LW-1:0] ren_src_a,
   input  logic [LW-1:0] ren_src_b,
   input  logic [LW-1:0] ren_dst,
   output logic          ren_ready,
   output logic [PW-1:0] ren_phys_a,
   output logic [PW-1:0] ren_phys_b,
   output logic [PW-1:0] ren_phys_dst,
   output logic [PW-1:0] ren_phys_prev,
   input  logic          cmt_valid,
   input  logic [LW-1:0] cmt_dst,
   input  logic [PW-1:0] cmt_phys_new,
   input  logic [PW-1:0] cmt_phys_old,
   input  logic          recover
);
   localparam int unsigned SPARE = NUM_PHYS - NUM_LOG;

   if (NUM_PHYS <= NUM_LOG + 1) begin : g_bad_sizes
      $error("rnm_rename_unit: need at least two spare physical registers");
   end
   if ((NUM_PHYS & (NUM_PHYS - 1)) != 0 || (NUM_LOG & (NUM_LOG - 1)) != 0) begin : g_bad_pow2
      $error("rnm_rename_unit: register counts must be powers of two");
   end

   logic                pool_empty;
   logic [PW-1:0]       pool_head;
   logic [PW-1:0]       cmt_cur;
   logic [NUM_PHYS-1:0] cmt_used;
   logic                ren_fire;
   logic                rel_fire;

   assign ren_ready    = !pool_empty && !recover;
   assign ren_fire     = ren_valid && ren_ready;
   assign rel_fire     = cmt_valid && !recover;
   assign ren_phys_dst = pool_head;

   rnm_map_table #(
      .NUM_LOG (NUM_LOG),
      .NUM_PHYS(NUM_PHYS),
      .LW      (LW),
      .PW      (PW)
   ) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_a_log    (ren_src_a),
      .rd_b_log    (ren_src_b),
      .rd_d_log    (ren_dst),
      .rd_a_phys   (ren_phys_a),
      .rd_b_phys   (ren_phys_b),
      .rd_d_phys   (ren_phys_prev),
      .spec_we     (ren_fire),
      .spec_log    (ren_dst),
      .spec_phys   (pool_head),
      .cmt_we      (cmt_valid),
      .cmt_log     (cmt_dst),
      .cmt_phys    (cmt_phys_new),
      .cmt_cur_phys(cmt_cur),
      .recover     (recover),
      .cmt_used    (cmt_used)
   );

   rnm_free_fifo #(
      .NUM_PHYS(NUM_PHYS),
      .DEPTH   (SPARE),
      .PW      (PW)
   ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (ren_fire),
      .head_phys(pool_head),
      .empty    (pool_empty),
      .push     (rel_fire),
      .push_phys(cmt_phys_old),
      .rebuild  (recover),
      .used     (cmt_used)
   );

   AST_CMT_PREV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rel_fire |-> cmt_cur == cmt_phys_old); // R6
   AST_STALL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pool_empty |-> !ren_ready); // R5
   AST_NO_RENAME_IN_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      recover |-> !ren_ready); // R8
   AST_FRESH_NOT_PREV: assert property (@(posedge clk) disable iff (!rst_n)
      ren_fire |-> ren_phys_dst != ren_phys_prev); // R3
endmodule

// File: tb/rnm_rename_unit_tb_top.sv
module rnm_rename_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ren_valid = 1'b0;
   logic [4:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
   logic       ren_ready;
   logic [5:0] ren_phys_a, ren_phys_b, ren_phys_dst, ren_phys_prev;
   logic       cmt_valid = 1'b0;
   logic [4:0] cmt_dst = '0;
   logic [5:0] cmt_phys_new = '0, cmt_phys_old = '0;
   logic       recover = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rnm_rename_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
      .ren_ready(ren_ready), .ren_phys_a(ren_phys_a), .ren_phys_b(ren_phys_b),
      .ren_phys_dst(ren_phys_dst), .ren_phys_prev(ren_phys_prev),
      .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_phys_new(cmt_phys_new),
      .cmt_phys_old(cmt_phys_old), .recover(recover)
   );

   typedef struct packed {
      logic [4:0] d;
      logic [5:0] n;
      logic [5:0] o;
   } rob_t;

   logic [5:0] m_spec [32];
   logic [5:0] m_cmt  [32];
   logic [5:0] m_free [$];
   rob_t       m_rob  [$];

   int   n_chk = 0;
   int   n_fail = 0;
   logic       obs_rdy;
   logic [5:0] obs_a, obs_b, obs_dst, obs_prev;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void model_rebuild();
      bit used [64];
      for (int p = 0; p < 64; p++) used[p] = 1'b0;
      for (int i = 0; i < 32; i++) used[m_cmt[i]] = 1'b1;
      m_free.delete();
      for (int p = 0; p < 64; p++) begin
         if (!used[p] && m_free.size() < 32) m_free.push_back(6'(p));
      end
   endfunction

   // one cycle: drive, check before the edge, update the model after it
   task automatic step(input bit v, input int sa, input int sb, input int d,
                       input bit c, input bit rec);
      rob_t e;
      bit   do_c;
      bit   exp_rdy;
      bit   fire;
      logic [5:0] front;
      e    = '0;
      do_c = c && (m_rob.size() != 0);
      if (do_c) e = m_rob[0];
      ren_valid    = v;
      ren_src_a    = 5'(sa);
      ren_src_b    = 5'(sb);
      ren_dst      = 5'(d);
      cmt_valid    = do_c;
      cmt_dst      = e.d;
      cmt_phys_new = e.n;
      cmt_phys_old = e.o;
      recover      = rec;
      @(negedge clk);
      obs_rdy  = ren_ready;
      obs_a    = ren_phys_a;
      obs_b    = ren_phys_b;
      obs_dst  = ren_phys_dst;
      obs_prev = ren_phys_prev;
      exp_rdy  = !rec && (m_free.size() != 0);
      check("R5", "ready", int'(obs_rdy), int'(exp_rdy));
      check("R3", "src a tag", int'(obs_a), int'(m_spec[sa]));
      check("R3", "src b tag", int'(obs_b), int'(m_spec[sb]));
      check("R3", "prev tag", int'(obs_prev), int'(m_spec[d]));
      if (exp_rdy) check("R3", "fresh tag", int'(obs_dst), int'(m_free[0]));
      fire  = v && exp_rdy;
      front = (m_free.size() != 0) ? m_free[0] : 6'd0;
      @(posedge clk);
      #1;
      if (rec) begin
         for (int i = 0; i < 32; i++) m_spec[i] = m_cmt[i];
         model_rebuild();
         m_rob.delete();
      end else begin
         if (fire) void'(m_free.pop_front());
         if (do_c) begin
            m_cmt[e.d] = e.n;
            m_free.push_back(e.o);
            void'(m_rob.pop_front());
         end
         if (fire) begin
            rob_t ne;
            ne.d = 5'(d);
            ne.n = front;
            ne.o = m_spec[d];
            m_rob.push_back(ne);
            m_spec[d] = front;
         end
      end
      ren_valid = 1'b0;
      cmt_valid = 1'b0;
      recover   = 1'b0;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      report();
   end

   initial begin
      void'($urandom(32'd4821));
      for (int i = 0; i < 32; i++) begin
         m_spec[i] = 6'(i);
         m_cmt[i]  = 6'(i);
      end
      for (int k = 32; k < 64; k++) m_free.push_back(6'(k));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: identity in both maps; recovery keeps lookups from renaming
      for (int i = 0; i < 32; i++) begin
         step(1'b1, i, 31 - i, i, 1'b0, 1'b1);
         check("R1", "reset map a", int'(obs_a), i);
         check("R1", "reset map b", int'(obs_b), 31 - i);
         check("R8", "ready low in recovery", int'(obs_rdy), 0);
      end

      // R2 ascending allocation, R4 source naming own destination
      for (int k = 0; k < 32; k++) begin
         step(1'b1, k, (k + 1) % 32, k, 1'b0, 1'b0);
         check("R2", "allocation order", int'(obs_dst), 32 + k);
         check("R4", "own dst source sees old", int'(obs_a), k);
      end

      // R5: pool empty, stalled request must not change anything
      step(1'b1, 0, 1, 2, 1'b0, 1'b0);
      check("R5", "stall when empty", int'(obs_rdy), 0);
      step(1'b0, 2, 2, 2, 1'b0, 1'b0);
      check("R5", "stalled rename left map", int'(obs_a), 34);

      // R7: release into empty pool, then paired release and allocation
      step(1'b1, 3, 3, 5, 1'b1, 1'b0);
      check("R7", "still stalled in release cycle", int'(obs_rdy), 0);
      step(1'b1, 5, 5, 6, 1'b1, 1'b0);
      check("R7", "released tag reused", int'(obs_dst), 0);
      check("R5", "stalled dst 5 kept", int'(obs_a), 37);
      step(1'b1, 6, 6, 7, 1'b1, 1'b0);
      check("R7", "paired alloc/release", int'(obs_dst), 1);

      // R6/R8: committed dst 0,1,2 -> 32,33,34; recover and inspect
      step(1'b0, 0, 0, 0, 1'b0, 1'b1);
      step(1'b0, 0, 1, 0, 1'b0, 1'b0);
      check("R6", "committed dst 0", int'(obs_a), 32);
      check("R6", "committed dst 1", int'(obs_b), 33);
      step(1'b0, 2, 3, 0, 1'b0, 1'b0);
      check("R6", "committed dst 2", int'(obs_a), 34);
      check("R8", "uncommitted dst 3 restored", int'(obs_b), 3);
      step(1'b1, 0, 0, 8, 1'b0, 1'b0);
      check("R8", "rebuilt pool first", int'(obs_dst), 0);
      step(1'b1, 0, 0, 9, 1'b0, 1'b0);
      check("R8", "rebuilt pool second", int'(obs_dst), 1);
      step(1'b1, 0, 0, 10, 1'b0, 1'b0);
      check("R8", "rebuilt pool third", int'(obs_dst), 2);
      step(1'b1, 0, 0, 11, 1'b0, 1'b0);
      check("R8", "rebuilt pool skips committed", int'(obs_dst), 35);

      // constrained random traffic against the model
      for (int t = 0; t < 4000; t++) begin
         bit v, c, r;
         v = ($urandom % 4) != 0;
         c = ($urandom % 5) < 3;
         r = ($urandom % 113) == 0;
         step(v, int'($urandom % 32), int'($urandom % 32), int'($urandom % 32), c, r);
      end
      report();
   end
endmodule